// File: doc/BRIEF.md
# Audio Codec Control Register File

This block keeps the control words of a stereo audio codec. Each word is 16 bits wide and sits at a 7-bit even index. The serial link front end hands the block single-cycle write and read strobes. Every strobe comes with an index, and a write also carries a data word. Reads return their word one cycle later. The block stores volume, mute, record source and record gain codes exactly as written, with unused bit positions forced to zero. It does not apply those codes to audio.

A few indices behave differently:

- A write of any value to index 00h puts every register back to its default. A read of 00h returns a fixed capability word.
- In the powerdown word at 26h, the low byte is live readiness status taken from four input pins. Software cannot write that byte.
- Both vendor identification indices return constants that are fixed at elaboration.
- Reserved and unimplemented indices read as zero and discard writes.

The stored codes are decoded into registered control outputs for the rest of the codec: powerdown requests, the general-purpose mode flags, the record sources and the mic boost.

Top module: `codec_regfile`

## Requirements
- R1: After `rst`, the registers read back their defaults:
  - 02h, 04h, 06h, 0Ah and 1Ch: 8000h
  - 0Ch and 0Eh: 8008h
  - 10h, 12h, 14h, 16h and 18h: 8808h
  - 1Ah, 20h and 26h: 0000h
- R2: A write of any data to index 00h restores every register to its R1 default. A read issued in the next cycle already sees the defaults.
- R3: A read of index 00h returns 0D50h.
- R4: `rd_valid` is high in the cycle after a cycle with `rd_en`, and low otherwise. `rd_data` carries the word for the index presented with `rd_en`. A read in the same cycle as a write returns the value held before that write.
- R5: Bits outside each register's writable mask read as zero, whatever was written. The masks are:
  - 02h, 04h and 10h–18h: 9F1Fh
  - 06h and 0Ch: 801Fh
  - 0Ah: 801Eh
  - 0Eh: 805Fh
  - 1Ah: 0707h
  - 1Ch: 8F0Fh
  - 20h: A380h
  - 26h: 7F00h
- R6: A read of 26h returns the stored bits 14:8 and zeros in bits 7:4. Bits 3:0 are the `rdy_i` value sampled in the read cycle: bit 3 is reference up, bit 2 mixer ready, bit 1 DAC ready, bit 0 ADC ready. A write cannot change bits 7:0.
- R7: The following indices read as zero and ignore writes, leaving every other register unchanged:
  - 08h, 1Eh, 22h and 24h
  - every index from 28h to 7Ah
  - every odd index
- R8: Index 7Ch reads `VID_HI` and index 7Eh reads `VID_LO` (defaults 5A31h and 0042h). Writes to either are ignored.
- R9: The five general-purpose flags follow the register at 20h, one cycle after it is written:
  - `pcm_post3d` is bit 15
  - `enh3d_on` is bit 13
  - `mono_mic` is bit 9
  - `mic2_sel` is bit 8
  - `loopback` is bit 7
- R10: `rec_src_l` is bits 10:8 and `rec_src_r` is bits 2:0 of the register at 1Ah, one cycle after it is written. Codes 0 to 7 select, in order: mic, CD, video, aux, line, stereo mix, mono mix and phone.
- R11: `pd_req[6:0]` is bits 14:8 of the register at 26h. `mic_boost` is bit 6 of the register at 0Eh. Both update one cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 7 | Register index |
| wdata | input | 16 | Write data |
| rdy_i | input | 4 | Live readiness status for the low nibble of 26h |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 16 | Read data |
| pcm_post3d | output | 1 | PCM path joins after the spatial enhancer |
| enh3d_on | output | 1 | Spatial enhancer enabled |
| mono_mic | output | 1 | Mono output takes the mic instead of the mix |
| mic2_sel | output | 1 | Second mic selected |
| loopback | output | 1 | ADC to DAC digital loop |
| rec_src_l | output | 3 | Left record source code |
| rec_src_r | output | 3 | Right record source code |
| mic_boost | output | 1 | 20 dB mic boost enable |
| pd_req | output | 7 | Powerdown requests |

## Verification
A corrupted stored word shows up in two places. It appears on `rd_data` at the very next read of that index. For 0Eh, 1Ah, 20h and 26h, it also appears on the decoded control outputs one cycle after it arises. A failed bulk reset through index 00h shows as a non-default value at the next read of any implemented index. A mask error shows as stray ones after an all-ones write. The bench compares every read and the control outputs after every write against a model of the registers, so a wrong state is reported within two cycles of the access that exposes it.

// File: rtl/codec_reg_pkg.sv
package codec_reg_pkg;
  localparam int DW    = 16;
  localparam int AW    = 7;
  localparam int NSLOT = 20;           // slots 00h..26h (index >> 1)
  localparam int SLOT_MIC  = 7;        // 0Eh
  localparam int SLOT_RSEL = 13;       // 1Ah
  localparam int SLOT_GP   = 16;       // 20h
  localparam int SLOT_PD   = 19;       // 26h
  localparam logic [DW-1:0] CAPS_WORD = 16'h0D50;

  typedef enum logic [2:0] {
    SRC_MIC, SRC_CD, SRC_VIDEO, SRC_AUX, SRC_LINE, SRC_SMIX, SRC_MMIX, SRC_PHONE
  } rec_src_e;

  function automatic logic [DW-1:0] slot_mask(input int i);
    case (i)
      1, 2, 8, 9, 10, 11, 12: slot_mask = 16'h9F1F;
      3, 6:                   slot_mask = 16'h801F;
      5:                      slot_mask = 16'h801E;
      7:                      slot_mask = 16'h805F;
      13:                     slot_mask = 16'h0707;
      14:                     slot_mask = 16'h8F0F;
      16:                     slot_mask = 16'hA380;
      19:                     slot_mask = 16'h7F00;
      default:                slot_mask = 16'h0000;
    endcase
  endfunction

  function automatic logic [DW-1:0] slot_dflt(input int i);
    case (i)
      1, 2, 3, 5, 14:     slot_dflt = 16'h8000;
      6, 7:               slot_dflt = 16'h8008;
      8, 9, 10, 11, 12:   slot_dflt = 16'h8808;
      default:            slot_dflt = 16'h0000;
    endcase
  endfunction
endpackage

// File: rtl/codec_reg_store.sv
module codec_reg_store
  import codec_reg_pkg::*;
#(
  parameter int N = NSLOT
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [AW-1:0]        addr,
  input  logic [DW-1:0]        wdata,
  output logic [N-1:0][DW-1:0] q
);
  localparam int SW = AW - 1;

  logic [SW-1:0] slot;
  logic          bulk_rst;
  assign slot     = addr[AW-1:1];
  assign bulk_rst = wr_en && (addr == '0);

  for (genvar i = 0; i < N; i++) begin : g_slot
    localparam logic [DW-1:0] MASK = slot_mask(i);
    localparam logic [DW-1:0] DFLT = slot_dflt(i);
    logic hit;
    assign hit = wr_en && !addr[0] && (slot == SW'(i));

    always_ff @(posedge clk) begin
      if (rst || bulk_rst) q[i] <= DFLT;
      else if (hit)        q[i] <= wdata & MASK;
    end

    p_bulk_reset_r2: assert property (@(posedge clk) disable iff (rst)
      bulk_rst |=> (q[i] == DFLT));
  end
endmodule

// File: rtl/codec_reg_rdmux.sv
module codec_reg_rdmux
  import codec_reg_pkg::*;
#(
  parameter int N = NSLOT,
  parameter logic [DW-1:0] VID_HI = 16'h5A31,
  parameter logic [DW-1:0] VID_LO = 16'h0042
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_en,
  input  logic [AW-1:0]        addr,
  input  logic [3:0]           rdy_i,
  input  logic [N-1:0][DW-1:0] q,
  output logic                 rd_valid,
  output logic [DW-1:0]        rd_data
);
  localparam int SW = AW - 1;
  localparam logic [AW-1:0] IDX_VH = 7'h7C;
  localparam logic [AW-1:0] IDX_VL = 7'h7E;

  logic [SW-1:0] slot;
  logic [DW-1:0] word;
  assign slot = addr[AW-1:1];

  always_comb begin
    word = '0;
    if (addr == IDX_VH)                      word = VID_HI;
    else if (addr == IDX_VL)                 word = VID_LO;
    else if (!addr[0] && int'(slot) < N) begin
      if (slot == '0)                        word = CAPS_WORD;
      else if (int'(slot) == SLOT_PD)        word = {q[SLOT_PD][15:8], 4'b0000, rdy_i};
      else                                   word = q[slot];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= word;
    end
  end

  p_caps_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == '0) |=> (rd_data == CAPS_WORD));
  p_latency_r4: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  p_idle_r4: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);
  p_status_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 7'h26) |=> (rd_data[7:0] == {4'b0000, $past(rdy_i)}));
  p_reserved_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr >= 7'h28 && addr <= 7'h7A) |=> (rd_data == '0));
endmodule

// File: rtl/codec_ctl_decode.sv
module codec_ctl_decode
  import codec_reg_pkg::*;
#(
  parameter int N = NSLOT
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0][DW-1:0] q,
  output logic                 pcm_post3d,
  output logic                 enh3d_on,
  output logic                 mono_mic,
  output logic                 mic2_sel,
  output logic                 loopback,
  output rec_src_e             rec_src_l,
  output rec_src_e             rec_src_r,
  output logic                 mic_boost,
  output logic [6:0]           pd_req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pcm_post3d <= 1'b0;
      enh3d_on   <= 1'b0;
      mono_mic   <= 1'b0;
      mic2_sel   <= 1'b0;
      loopback   <= 1'b0;
      rec_src_l  <= SRC_MIC;
      rec_src_r  <= SRC_MIC;
      mic_boost  <= 1'b0;
      pd_req     <= '0;
    end else begin
      pcm_post3d <= q[SLOT_GP][15];
      enh3d_on   <= q[SLOT_GP][13];
      mono_mic   <= q[SLOT_GP][9];
      mic2_sel   <= q[SLOT_GP][8];
      loopback   <= q[SLOT_GP][7];
      rec_src_l  <= rec_src_e'(q[SLOT_RSEL][10:8]);
      rec_src_r  <= rec_src_e'(q[SLOT_RSEL][2:0]);
      mic_boost  <= q[SLOT_MIC][6];
      pd_req     <= q[SLOT_PD][14:8];
    end
  end

  p_gp_follow_r9: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (enh3d_on == $past(q[SLOT_GP][13])));
  p_pd_follow_r11: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (pd_req == $past(q[SLOT_PD][14:8])));
endmodule

// File: rtl/codec_regfile.sv
module codec_regfile
  import codec_reg_pkg::*;
#(
  parameter logic [15:0] VID_HI = 16'h5A31,
  parameter logic [15:0] VID_LO = 16'h0042
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [6:0]  addr,
  input  logic [15:0] wdata,
  input  logic [3:0]  rdy_i,
  output logic        rd_valid,
  output logic [15:0] rd_data,
  output logic        pcm_post3d,
  output logic        enh3d_on,
  output logic        mono_mic,
  output logic        mic2_sel,
  output logic        loopback,
  output logic [2:0]  rec_src_l,
  output logic [2:0]  rec_src_r,
  output logic        mic_boost,
  output logic [6:0]  pd_req
);
  logic [NSLOT-1:0][DW-1:0] q;
  rec_src_e src_l, src_r;

  codec_reg_store #(.N(NSLOT)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .q(q));

  codec_reg_rdmux #(.N(NSLOT), .VID_HI(VID_HI), .VID_LO(VID_LO)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .rdy_i(rdy_i), .q(q),
    .rd_valid(rd_valid), .rd_data(rd_data));

  codec_ctl_decode #(.N(NSLOT)) u_dec (
    .clk(clk), .rst(rst), .q(q),
    .pcm_post3d(pcm_post3d), .enh3d_on(enh3d_on), .mono_mic(mono_mic),
    .mic2_sel(mic2_sel), .loopback(loopback), .rec_src_l(src_l),
    .rec_src_r(src_r), .mic_boost(mic_boost), .pd_req(pd_req));

  assign rec_src_l = src_l;
  assign rec_src_r = src_r;
endmodule

// File: tb/tb_codec_regfile.sv
module tb_codec_regfile;
  logic clk = 1'b0;
  logic rst, wr_en, rd_en;
  logic [6:0] addr;
  logic [15:0] wdata;
  logic [3:0] rdy_i;
  logic rd_valid;
  logic [15:0] rd_data;
  logic pcm_post3d, enh3d_on, mono_mic, mic2_sel, loopback, mic_boost;
  logic [2:0] rec_src_l, rec_src_r;
  logic [6:0] pd_req;

  int total = 0, bad = 0;
  bit done = 0;
  logic [15:0] m [0:127];

  always #2 clk = ~clk;

  codec_regfile dut (.*);

  function automatic logic [15:0] bm(input int a);
    case (a)
      'h02, 'h04, 'h10, 'h12, 'h14, 'h16, 'h18: bm = 16'h9F1F;
      'h06, 'h0C: bm = 16'h801F;
      'h0A: bm = 16'h801E;
      'h0E: bm = 16'h805F;
      'h1A: bm = 16'h0707;
      'h1C: bm = 16'h8F0F;
      'h20: bm = 16'hA380;
      'h26: bm = 16'h7F00;
      default: bm = 16'h0000;
    endcase
  endfunction

  function automatic logic [15:0] bd(input int a);
    case (a)
      'h02, 'h04, 'h06, 'h0A, 'h1C: bd = 16'h8000;
      'h0C, 'h0E: bd = 16'h8008;
      'h10, 'h12, 'h14, 'h16, 'h18: bd = 16'h8808;
      default: bd = 16'h0000;
    endcase
  endfunction

  function automatic logic [15:0] exp_rd(input int a, input logic [3:0] r);
    if (a == 'h7C) return 16'h5A31;
    if (a == 'h7E) return 16'h0042;
    if (a == 0) return 16'h0D50;
    if (a == 'h26) return {m[a][15:8], 4'b0000, r};
    return m[a];
  endfunction

  task automatic model_defaults();
    for (int i = 0; i < 128; i++) m[i] = bd(i);
  endtask

  task automatic model_write(input int a, input logic [15:0] d);
    if (a == 0) model_defaults();
    else m[a] = d & bm(a);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input int a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = 7'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
  endtask

  task automatic do_read(input int a, input logic [3:0] r, output logic [15:0] v);
    @(negedge clk);
    rd_en = 1'b1; addr = 7'(a); rdy_i = r;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
    chk("R4 valid", 32'(rd_valid), 32'd1);
  endtask

  task automatic check_ctl(input string tag);
    @(negedge clk);
    chk({tag, " R9 gp"}, 32'({pcm_post3d, enh3d_on, mono_mic, mic2_sel, loopback}),
        32'({m['h20][15], m['h20][13], m['h20][9], m['h20][8], m['h20][7]}));
    chk({tag, " R10 src"}, 32'({rec_src_l, rec_src_r}),
        32'({m['h1A][10:8], m['h1A][2:0]}));
    chk({tag, " R11 pd"}, 32'({mic_boost, pd_req}), 32'({m['h0E][6], m['h26][14:8]}));
  endtask

  task automatic read_chk(input string req, input int a);
    logic [15:0] v;
    logic [3:0] r;
    r = 4'($urandom);
    do_read(a, r, v);
    chk($sformatf("%s idx=%0h", req, a), 32'(v), 32'(exp_rd(a, r)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd1234));
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; rdy_i = '0;
    model_defaults();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R4 idle", 32'(rd_valid), 32'd0);

    // R1 defaults at every implemented index
    for (int a = 2; a <= 'h26; a += 2) read_chk("R1", a);
    check_ctl("reset");
    // R3 capability word
    read_chk("R3", 0);
    // R5 all-ones writes show the masks
    for (int a = 2; a <= 'h26; a += 2) begin
      do_write(a, 16'hFFFF);
      read_chk("R5", a);
    end
    check_ctl("ones");
    // R6 status nibble follows rdy_i, writes cannot touch low byte
    do_read('h26, 4'b1010, v);
    chk("R6 status", 32'(v), 32'h7F0A);
    do_read('h26, 4'b0101, v);
    chk("R6 status", 32'(v), 32'h7F05);
    // R7 reserved and odd indices; neighbour intact
    do_write('h22, 16'hFFFF); read_chk("R7", 'h22);
    do_write('h40, 16'h1234); read_chk("R7", 'h40);
    do_write('h0D, 16'hFFFF); read_chk("R7 odd", 'h0D);
    read_chk("R7 neighbour", 'h0C);
    read_chk("R7 neighbour", 'h0E);
    // R8 vendor words
    do_write('h7C, 16'h0000); read_chk("R8", 'h7C);
    do_write('h7E, 16'hFFFF); read_chk("R8", 'h7E);
    // R2 bulk reset through 00h
    do_write(0, 16'h0000);
    for (int a = 2; a <= 'h26; a += 2) read_chk("R2", a);
    check_ctl("bulk");
    // R4 read alongside write returns old value
    @(negedge clk);
    wr_en = 1'b1; rd_en = 1'b1; addr = 7'h02; wdata = 16'h0101;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk("R4 same-cycle", 32'(rd_data), 32'h8000);
    model_write('h02, 16'h0101);
    read_chk("R4 after", 'h02);
    // R10 each record source code
    for (int c = 0; c < 8; c++) begin
      do_write('h1A, 16'({5'b0, 3'(c), 5'b0, 3'(7 - c)}));
      check_ctl("R10 code");
    end
    // random traffic
    for (int n = 0; n < 600; n++) begin
      int a;
      logic [15:0] d;
      a = ($urandom % 2) ? 2 * int'($urandom % 20) : int'($urandom % 128);
      d = 16'($urandom);
      if (($urandom % 2) == 0) begin
        if (a == 0 && ($urandom % 4) != 0) a = 2;
        do_write(a, d);
        check_ctl("rand");
      end else begin
        read_chk("R5 rand", a);
      end
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule